// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

A register-mapped general-purpose I/O block for up to 32 pins. Software writes per-pin output values and output enables, which drive the pad-side `pin_out` and `pin_oe` vectors directly. The pad inputs pass through a two-stage synchronizer. The synchronized value can be read back and also feeds the interrupt logic.

Each pin has two interrupt sources, and each source has its own mask and polarity. The level source is live: it is the synchronized input XOR the level polarity bit, then gated by the level mask. The edge source is sticky. A selected edge sets a bit in the event register, that bit stays set until software writes a one to it, and the event mask then gates it. All per-pin requests are ORed into bit 0 of the status register. Bit 0 of the top-level mask register gates that summary onto the single `irq_out` line.

The bus is a plain synchronous read/write port. A write takes effect on the clock edge where `bus_wr_en` is sampled. A read sampled on an edge returns its data in `bus_rdata` from that edge on. The port has no handshake or back-pressure, and every access completes in one cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register is zero. `pin_oe`, `pin_out` and `irq_out` are 0, and reads of every register return 0.
- R2: Offset 0x44 holds the output values and offset 0x48 holds the output enables (1 = drive the pin). Both read back as written and appear on `pin_out` and `pin_oe` after the write edge. `bus_rdata` carries the value sampled at the edge where `bus_rd_en` is seen.
- R3: Offset 0x40 returns `pin_in` after a two-flop synchronizer. A change applied between edges shows up in a read sampled on the third edge after the change, but not in a read sampled on the second. Writes to 0x40 have no effect.
- R4: The level request of pin i is (synchronized input[i] XOR level polarity[i]) AND level mask[i]. Level polarity is at 0x50, where 1 means active-low. The level mask is at 0x54.
- R5: Edge polarity is at 0x64. Bit value 0 selects the rising edge and 1 selects the falling edge. A selected edge on the synchronized input sets that pin's bit in the event register at 0x58. The opposite edge sets nothing.
- R6: Writing to 0x58 clears each bit written as 1 and leaves each bit written as 0 unchanged. If an edge and a clear hit the same bit on the same edge, the bit stays set.
- R7: An event bit latches whether or not it is masked. The edge request is event AND event mask, with the event mask at 0x5C.
- R8: Bit 0 of status (0x00) is the OR over all pins of (level request OR edge request). The status register is read-only, and its other bits read 0.
- R9: `irq_out` equals status bit 0 AND bit 0 of the top-level mask register (0x04). Only bit 0 of that register is stored, and reads of it return bit 0 alone.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pin_in | input | NUM_PINS (32) | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS (32) | Output values to the pads |
| pin_oe | output | NUM_PINS (32) | Output enables to the pads |
| irq_out | output | 1 | Interrupt request |

## Verification
The level path is driven through a table of input, polarity and mask triples. The table separates active-high from active-low behaviour, a masked pin from an unmasked one, and the lowest pin from the highest. The edge path is tested in several ways:
- a rising edge with rising select, and a falling edge with rising select;
- each edge with falling select;
- events that latch while masked and then raise the interrupt once unmasked;
- clear writes of zeros and of ones, and a clear that collides with a new edge.

Read timing against the synchronizer depth is probed by reading repeatedly right after an input change. Unmapped and read-only offsets are written to show that no register moves.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  // Byte offsets of the register map
  localparam int unsigned OFS_STATUS   = 'h00;
  localparam int unsigned OFS_TOP_EN   = 'h04;
  localparam int unsigned OFS_DIN      = 'h40;
  localparam int unsigned OFS_DOUT     = 'h44;
  localparam int unsigned OFS_OE       = 'h48;
  localparam int unsigned OFS_LVL_POL  = 'h50;
  localparam int unsigned OFS_LVL_MSK  = 'h54;
  localparam int unsigned OFS_EVT      = 'h58;
  localparam int unsigned OFS_EVT_MSK  = 'h5C;
  localparam int unsigned OFS_EDGE_POL = 'h64;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_events.sv
module gpio_edge_events #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] fall_sel,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] clr_bits;

  // A changed bit whose new value differs from the select is the chosen edge
  assign hit      = (smp ^ prev_q) & (smp ^ fall_sel);
  assign clr_bits = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= smp;
      evt_q  <= (evt_q & ~clr_bits) | hit;  // set beats clear
    end

  // R6: a bit only drops when a clear write addressed it
  a_r6_only_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_q) & ~evt_q) & ~$past(clr_bits)) == '0));

  generate
    for (genvar i = 0; i < W; i++) begin : g_chk
      // R5: a selected edge on the sampled input is latched
      a_r5_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(smp[i]) && !fall_sel[i]) || ($fell(smp[i]) && fall_sel[i]))
        |=> evt_q[i]);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] smp,
  input  logic [W-1:0] lvl_pol,
  input  logic [W-1:0] lvl_msk,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] evt_msk,
  input  logic         top_en,
  output logic         summary,
  output logic         irq
);
  logic [W-1:0] lvl_req;
  logic [W-1:0] edge_req;

  assign lvl_req  = (smp ^ lvl_pol) & lvl_msk;
  assign edge_req = evt & evt_msk;
  assign summary  = |(lvl_req | edge_req);
  assign irq      = summary & top_en;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_TOP_EN   = ADDR_W'(OFS_TOP_EN);
  localparam logic [ADDR_W-1:0] A_DIN      = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_DOUT     = ADDR_W'(OFS_DOUT);
  localparam logic [ADDR_W-1:0] A_OE       = ADDR_W'(OFS_OE);
  localparam logic [ADDR_W-1:0] A_LVL_POL  = ADDR_W'(OFS_LVL_POL);
  localparam logic [ADDR_W-1:0] A_LVL_MSK  = ADDR_W'(OFS_LVL_MSK);
  localparam logic [ADDR_W-1:0] A_EVT      = ADDR_W'(OFS_EVT);
  localparam logic [ADDR_W-1:0] A_EVT_MSK  = ADDR_W'(OFS_EVT_MSK);
  localparam logic [ADDR_W-1:0] A_EDGE_POL = ADDR_W'(OFS_EDGE_POL);

  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] dout_q, oe_q, lpol_q, lmsk_q, emsk_q, epol_q;
  logic                top_en_q;
  logic [NUM_PINS-1:0] smp, evt;
  logic                summary;
  logic [DATA_W-1:0]   rd_mux;

  assign wbits = bus_wdata[NUM_PINS-1:0];

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return bus_wr_en && (bus_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dout_q   <= '0;
      oe_q     <= '0;
      lpol_q   <= '0;
      lmsk_q   <= '0;
      emsk_q   <= '0;
      epol_q   <= '0;
      top_en_q <= 1'b0;
    end else begin
      if (wr_at(A_DOUT))     dout_q   <= wbits;
      if (wr_at(A_OE))       oe_q     <= wbits;
      if (wr_at(A_LVL_POL))  lpol_q   <= wbits;
      if (wr_at(A_LVL_MSK))  lmsk_q   <= wbits;
      if (wr_at(A_EVT_MSK))  emsk_q   <= wbits;
      if (wr_at(A_EDGE_POL)) epol_q   <= wbits;
      if (wr_at(A_TOP_EN))   top_en_q <= bus_wdata[0];
    end

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (smp)
  );

  gpio_edge_events #(.W(NUM_PINS)) u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (smp),
    .fall_sel (epol_q),
    .clr_we   (wr_at(A_EVT)),
    .clr_mask (wbits),
    .evt_q    (evt)
  );

  gpio_irq_merge #(.W(NUM_PINS)) u_merge (
    .smp     (smp),
    .lvl_pol (lpol_q),
    .lvl_msk (lmsk_q),
    .evt     (evt),
    .evt_msk (emsk_q),
    .top_en  (top_en_q),
    .summary (summary),
    .irq     (irq_out)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_STATUS:   rd_mux = DATA_W'(summary);
      A_TOP_EN:   rd_mux = DATA_W'(top_en_q);
      A_DIN:      rd_mux = DATA_W'(smp);
      A_DOUT:     rd_mux = DATA_W'(dout_q);
      A_OE:       rd_mux = DATA_W'(oe_q);
      A_LVL_POL:  rd_mux = DATA_W'(lpol_q);
      A_LVL_MSK:  rd_mux = DATA_W'(lmsk_q);
      A_EVT:      rd_mux = DATA_W'(evt);
      A_EVT_MSK:  rd_mux = DATA_W'(emsk_q);
      A_EDGE_POL: rd_mux = DATA_W'(epol_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;

  assign pin_out = dout_q;
  assign pin_oe  = oe_q;

  // R9: the line never rises while the top-level enable is off
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> top_en_q);

  // R2/R10: enables move only on a write to their own offset
  a_r2_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && bus_addr == A_OE) |=> $stable(pin_oe));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // Level vectors: input, polarity, mask
  localparam logic [31:0] T_IN  [7] = '{32'h0, 32'h20, 32'h20, 32'h0,
                                        32'h200, 32'hFFFF_FFFF, 32'h8000_0000};
  localparam logic [31:0] T_POL [7] = '{32'h0, 32'h0, 32'h0, 32'h200,
                                        32'h200, 32'hFFFF_FFFF, 32'h0};
  localparam logic [31:0] T_MSK [7] = '{32'hFFFF_FFFF, 32'h20, 32'h40, 32'h200,
                                        32'h200, 32'hFFFF_FFFF, 32'h8000_0000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        exp_lvl;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    rd(8'h48, d); chk("R1 oe reg", d, 0);
    rd(8'h58, d); chk("R1 event reg", d, 0);
    rd(8'h04, d); chk("R1 top mask", d, 0);

    // R2 outputs
    wr(8'h44, 32'hA5A5_5A5A);
    wr(8'h48, 32'h0F0F_0F0F);
    chk("R2 pin_out", pin_out, 32'hA5A5_5A5A);
    chk("R2 pin_oe", pin_oe, 32'h0F0F_0F0F);
    rd(8'h44, d); chk("R2 dout readback", d, 32'hA5A5_5A5A);
    rd(8'h48, d); chk("R2 oe readback", d, 32'h0F0F_0F0F);

    // R3 synchronizer latency and read-only input data
    pin_in = 32'h1234_5678;
    rd(8'h40, d); chk("R3 first edge still old", d, 0);
    rd(8'h40, d); chk("R3 second edge still old", d, 0);
    rd(8'h40, d); chk("R3 third edge new", d, 32'h1234_5678);
    wr(8'h40, 32'h0);
    rd(8'h40, d); chk("R3 write ignored", d, 32'h1234_5678);

    // R4 R8 R9 level table
    wr(8'h04, 32'h1);
    for (int k = 0; k < 7; k++) begin
      pin_in = T_IN[k];
      wr(8'h50, T_POL[k]);
      wr(8'h54, T_MSK[k]);
      idle(3);
      exp_lvl = |((T_IN[k] ^ T_POL[k]) & T_MSK[k]);
      rd(8'h00, d); chk("R4 R8 level status", d, {31'b0, exp_lvl});
      chk("R9 irq follows level", {31'b0, irq_out}, {31'b0, exp_lvl});
    end
    // last vector leaves an active request on pin 31
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R8 status read-only", d, 1);
    wr(8'h04, 32'hFFFF_FFFE);
    chk("R9 irq off when top mask cleared", {31'b0, irq_out}, 0);
    rd(8'h00, d); chk("R9 status still set", d, 1);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R9 top mask keeps bit0 only", d, 1);

    // Prepare edge tests
    wr(8'h54, 32'h0);
    pin_in = 32'h0;
    idle(4);
    wr(8'h58, 32'hFFFF_FFFF);
    rd(8'h58, d); chk("R6 all events cleared", d, 0);

    // R5 R7 rising edge, masked at first
    pin_in = 32'h8;
    idle(4);
    rd(8'h58, d); chk("R5 R7 rising latched while masked", d, 32'h8);
    rd(8'h00, d); chk("R7 masked event gives no status", d, 0);
    wr(8'h5C, 32'h8);
    rd(8'h00, d); chk("R7 unmasked event status", d, 1);
    chk("R9 irq from edge", {31'b0, irq_out}, 1);
    pin_in = 32'h0;
    idle(4);
    rd(8'h58, d); chk("R5 sticky after pin returns", d, 32'h8);
    wr(8'h58, 32'h0);
    rd(8'h58, d); chk("R6 zero write keeps event", d, 32'h8);
    wr(8'h58, 32'h8);
    rd(8'h58, d); chk("R6 one write clears", d, 0);
    chk("R7 irq drops after clear", {31'b0, irq_out}, 0);

    // R5 falling select
    wr(8'h64, 32'h10);
    pin_in = 32'h10;
    idle(4);
    rd(8'h58, d); chk("R5 rise ignored with falling select", d, 0);
    pin_in = 32'h0;
    idle(4);
    rd(8'h58, d); chk("R5 falling edge latched", d, 32'h10);
    wr(8'h58, 32'h10);

    // R6 collision: edge and clear on the same edge
    pin_in = 32'h8;
    idle(2);
    wr(8'h58, 32'h8);
    rd(8'h58, d); chk("R6 set wins over clear", d, 32'h8);

    // R10 unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R10 unmapped read zero", d, 0);
    rd(8'h60, d); chk("R10 unmapped read zero 0x60", d, 0);
    rd(8'h48, d); chk("R10 oe untouched", d, 32'h0F0F_0F0F);
    rd(8'h44, d); chk("R10 dout untouched", d, 32'hA5A5_5A5A);
    rd(8'h5C, d); chk("R10 event mask untouched", d, 32'h8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule